// File: doc/BRIEF.md
# UART Low-Power Sleep and Wake Controller

This block decides when a four-channel UART may stop its clock, and when it must start it again. Each channel supplies a sleep-enable bit, an interrupt-pending flag, its serial receive line, a strobe that marks a byte written into its transmit path, its four modem-status inputs, and a strobe that marks a read of its modem-status register. The block asserts a sleep indication together with a clock-gate request once every channel is quiet and has stayed quiet for a set number of cycles.

While asleep, any of three things wakes the device: a start-bit edge on a receive line, a byte loaded for transmission, or a change of level on a modem input. On a wake the clock gate is released at once. A settle counter then holds a ready flag low, which models the time an oscillator needs to start. A modem-input change stays latched per channel until that channel's status register is read. When every wake cause has cleared, the block returns to sleep by itself. Software does not need to issue another command.

The receive, transmit-strobe and modem inputs each pass through a two-flop synchroniser before edge detection. A single-cycle pulse marks each wake, and a per-channel cause vector records which channels produced the most recent one.

Top module: `uart_sleep_ctrl`

## Requirements
- R1: After reset the block is awake: `asleep`, `clk_gate`, `wake_pulse`, `modem_chg` and `wake_cause` are all 0, and `osc_ready` is 1.
- R2: The block sets `asleep` (and `clk_gate`, which equals it) only after IDLE_CYCLES consecutive cycles in which all of the following hold: every `sleep_en` bit is 1, no `irq_pend` bit is set, no `modem_chg` bit is set, every synchronised receive line is 1, no wake event is seen, and `osc_ready` is 1. With only some `sleep_en` bits set, the block never sleeps.
- R3: While any `irq_pend` bit is 1 the block does not enter sleep, and it sleeps once the flags clear.
- R4: While the block is asleep, a 1-to-0 transition on `rx[ch]` wakes it, and `wake_cause` bit ch is set.
- R5: While the block is asleep, a one-cycle pulse on `tx_load[ch]` wakes it, and `wake_cause` bit ch is set.
- R6: Channel ch's modem inputs are `modem_in[4*ch+3:4*ch]`. A change of level on any of them sets `modem_chg[ch]`, whether the block is awake or asleep, and wakes a sleeping block. Only a pulse on `msr_rd[ch]` clears the latch. A set latch blocks sleep.
- R7: Each event-driven wake produces exactly one single-cycle `wake_pulse`. Events that arrive while the block is awake produce no pulse.
- R8: Clearing any `sleep_en` bit while asleep ends sleep on the next clock edge. This produces no `wake_pulse`, and the block stays awake while the bit is 0.
- R9: After leaving sleep, `osc_ready` stays 0 for exactly SETTLE_CYCLES cycles and then returns to 1. Sleep is not entered while `osc_ready` is 0.
- R10: After a wake, once its causes have cleared and sleep is still enabled, the block returns to sleep by itself.
- R11: An input change becomes a wake on the third rising clock edge after it: two synchroniser stages, then the registered state update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_en | input | NCH | Per-channel sleep-enable control bit |
| irq_pend | input | NCH | Per-channel interrupt-pending flag |
| rx | input | NCH | Serial receive lines, idle high |
| tx_load | input | NCH | Strobe: byte written to the channel's transmit holding register or FIFO |
| modem_in | input | 4*NCH | Modem inputs, four per channel |
| msr_rd | input | NCH | Strobe: the channel's modem-status register is read |
| asleep | output | 1 | Sleep indication |
| clk_gate | output | 1 | Request to stop the oscillator/clock |
| wake_pulse | output | 1 | One-cycle pulse on an event-driven wake |
| modem_chg | output | NCH | Latched modem-input change per channel |
| wake_cause | output | NCH | Channels that caused the most recent wake |
| osc_ready | output | 1 | Oscillator settled, normal operation |

## Verification
Assertions check four rules on every cycle. Sleep never begins with an interrupt pending or while the settle counter runs. A wake pulse lasts one cycle and only accompanies a drop out of sleep. A modem latch falls only after a status read of its own channel. The bench scenarios are needed for the rest: the exact idle count before sleep, the exact settle length, the three-edge wake latency, the per-channel cause vector, and the automatic return to sleep after service. The random scenarios mix event kinds and channels, and each one is checked against cause and latch values that the bench computes itself.

// File: rtl/uart_sleep_ctrl.sv
module uart_sleep_ctrl #(
  parameter int NCH           = 4,
  parameter int IDLE_CYCLES   = 16,
  parameter int SETTLE_CYCLES = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NCH-1:0]   sleep_en,
  input  logic [NCH-1:0]   irq_pend,
  input  logic [NCH-1:0]   rx,
  input  logic [NCH-1:0]   tx_load,
  input  logic [4*NCH-1:0] modem_in,
  input  logic [NCH-1:0]   msr_rd,
  output logic             asleep,
  output logic             clk_gate,
  output logic             wake_pulse,
  output logic [NCH-1:0]   modem_chg,
  output logic [NCH-1:0]   wake_cause,
  output logic             osc_ready
);
  localparam int MW = 4 * NCH;
  localparam int IW = $clog2(IDLE_CYCLES + 1);
  localparam int SW = $clog2(SETTLE_CYCLES + 1);

  logic [NCH-1:0] rx_s1, rx_s2, rx_s3, tx_s1, tx_s2;
  logic [MW-1:0]  md_s1, md_s2, md_s3;
  logic [NCH-1:0] md_edge, ev;
  logic [IW-1:0]  idle_cnt;
  logic [SW-1:0]  settle_cnt;
  logic           any_ev, quiet;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_s1 <= '1; rx_s2 <= '1; rx_s3 <= '1;
      tx_s1 <= '0; tx_s2 <= '0;
      md_s1 <= '1; md_s2 <= '1; md_s3 <= '1;
    end else begin
      rx_s1 <= rx;       rx_s2 <= rx_s1; rx_s3 <= rx_s2;
      tx_s1 <= tx_load;  tx_s2 <= tx_s1;
      md_s1 <= modem_in; md_s2 <= md_s1; md_s3 <= md_s2;
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    assign md_edge[g] = |(md_s3[4*g +: 4] ^ md_s2[4*g +: 4]);
  end

  assign ev       = (rx_s3 & ~rx_s2) | tx_s2 | md_edge;
  assign any_ev   = |ev;
  assign quiet    = (&sleep_en) && !(|irq_pend) && !(|modem_chg) && (&rx_s2) && !any_ev && osc_ready;
  assign clk_gate = asleep;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) modem_chg <= '0;
    else        modem_chg <= (modem_chg & ~msr_rd) | md_edge;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      asleep     <= 1'b0;
      wake_pulse <= 1'b0;
      wake_cause <= '0;
      idle_cnt   <= '0;
    end else begin
      wake_pulse <= 1'b0;
      if (asleep) begin
        idle_cnt <= '0;
        if (!(&sleep_en)) asleep <= 1'b0;
        else if (any_ev) begin
          asleep     <= 1'b0;
          wake_pulse <= 1'b1;
          wake_cause <= ev;
        end
      end else if (quiet) begin
        if (idle_cnt == IW'(IDLE_CYCLES - 1)) begin
          asleep   <= 1'b1;
          idle_cnt <= '0;
        end else idle_cnt <= idle_cnt + 1'b1;
      end else idle_cnt <= '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      osc_ready  <= 1'b1;
      settle_cnt <= '0;
    end else if (asleep) begin
      osc_ready  <= 1'b0;
      settle_cnt <= '0;
    end else if (!osc_ready) begin
      if (settle_cnt == SW'(SETTLE_CYCLES - 1)) osc_ready <= 1'b1;
      else settle_cnt <= settle_cnt + 1'b1;
    end
  end

  p_no_sleep_irq_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(asleep) |-> ($past(irq_pend) == '0));
  p_no_sleep_settling_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!osc_ready && !asleep) |=> !asleep);
  p_pulse_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |=> !wake_pulse);
  p_pulse_on_wake_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |-> ($past(asleep) && !asleep));
  p_sleep_enabled_r8: assert property (@(posedge clk) disable iff (!rst_n)
    asleep |-> $past(&sleep_en));
  for (genvar g = 0; g < NCH; g++) begin : g_chk
    p_latch_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(modem_chg[g]) |-> $past(msr_rd[g]));
  end
endmodule

// File: tb/tb_uart_sleep_ctrl.sv
module tb_uart_sleep_ctrl;
  localparam int NCH = 4, IDLE = 16, SETTLE = 32;

  logic clk = 0, rst_n = 0;
  logic [NCH-1:0] sleep_en = '0, irq_pend = '0, rx = '1, tx_load = '0, msr_rd = '0;
  logic [4*NCH-1:0] modem_in = '1;
  logic asleep, clk_gate, wake_pulse, osc_ready;
  logic [NCH-1:0] modem_chg, wake_cause;
  int checks = 0, errors = 0, pulses = 0;

  always #10 clk = ~clk;

  uart_sleep_ctrl #(.NCH(NCH), .IDLE_CYCLES(IDLE), .SETTLE_CYCLES(SETTLE)) dut (
    .clk, .rst_n, .sleep_en, .irq_pend, .rx, .tx_load, .modem_in, .msr_rd,
    .asleep, .clk_gate, .wake_pulse, .modem_chg, .wake_cause, .osc_ready);

  always @(posedge clk) if (wake_pulse) pulses++;

  function automatic logic [NCH-1:0] chan_bit(int ch);
    return NCH'(1) << ch;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // kind 0: rx start edge (R4), 1: tx load (R5), 2: modem change (R6)
  task automatic wake_and_resleep(int kind, int ch, int bitn);
    int p0 = pulses;
    logic [NCH-1:0] exp_chg;
    chk("R10 precondition asleep", asleep, 1);
    exp_chg = (kind == 2) ? chan_bit(ch) : '0;
    case (kind)
      0: rx[ch] = 1'b0;
      1: tx_load[ch] = 1'b1;
      default: modem_in[4*ch + bitn] = ~modem_in[4*ch + bitn];
    endcase
    cyc(1);
    tx_load = '0;
    cyc(3);
    chk(kind == 0 ? "R4 woke" : kind == 1 ? "R5 woke" : "R6 woke", asleep, 0);
    chk("R7 one pulse", pulses - p0, 1);
    chk("R4/R5/R6 cause", wake_cause, chan_bit(ch));
    chk("R6 latch", modem_chg, exp_chg);
    chk("R9 settling", osc_ready, 0);
    if (kind == 2) begin
      cyc(SETTLE + IDLE + 4);
      chk("R6 latch blocks sleep", asleep, 0);
      chk("R6 latch held", modem_chg, exp_chg);
      msr_rd[ch] = 1'b1; cyc(1); msr_rd = '0;
      chk("R6 read clears", modem_chg, 0);
    end
    rx = '1;
    cyc(SETTLE + IDLE + 6);
    chk("R10 auto resleep", asleep, 1);
    chk("R2 gate follows", clk_gate, 1);
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    int n;
    void'($urandom(32'h5EED_1234));
    cyc(3);
    chk("R1 asleep", asleep, 0);
    chk("R1 gate", clk_gate, 0);
    chk("R1 ready", osc_ready, 1);
    chk("R1 latch", modem_chg, 0);
    chk("R1 cause", wake_cause, 0);
    chk("R1 pulse", wake_pulse, 0);
    rst_n = 1;
    cyc(3);

    sleep_en = 4'b1011;
    cyc(IDLE * 3);
    chk("R2 partial enable", asleep, 0);

    sleep_en = '1;
    cyc(IDLE - 1);
    chk("R2 before count", asleep, 0);
    cyc(1);
    chk("R2 after count", asleep, 1);
    chk("R2 gate", clk_gate, 1);

    // R8: disable while asleep
    n = pulses;
    sleep_en[2] = 1'b0;
    cyc(1);
    chk("R8 leaves sleep", asleep, 0);
    cyc(SETTLE + IDLE * 2);
    chk("R8 stays awake", asleep, 0);
    chk("R8 no pulse", pulses - n, 0);

    // R3: interrupts block sleep
    irq_pend = 4'b0100;
    sleep_en = '1;
    cyc(IDLE * 3);
    chk("R3 blocked", asleep, 0);
    irq_pend = '0;
    cyc(IDLE + 1);
    chk("R3 sleeps after clear", asleep, 1);

    // R11 latency and R9 exact settle length
    tx_load[1] = 1'b1; cyc(1); tx_load = '0;
    cyc(1);
    chk("R11 not yet", asleep, 1);
    cyc(1);
    chk("R11 woke on third edge", asleep, 0);
    n = 1;
    while (!osc_ready && n < 200) begin cyc(1); if (!osc_ready) n++; end
    chk("R9 settle length", n, SETTLE);
    cyc(IDLE + 4);
    chk("R10 resleep", asleep, 1);

    // R7/R6: events while awake
    sleep_en[0] = 1'b0;
    cyc(SETTLE + 4);
    n = pulses;
    modem_in[9] = ~modem_in[9];
    tx_load[3] = 1'b1; cyc(1); tx_load = '0;
    cyc(4);
    chk("R7 no pulse awake", pulses - n, 0);
    chk("R6 latch while awake", modem_chg, chan_bit(2));
    msr_rd[1] = 1'b1; cyc(1); msr_rd = '0;
    chk("R6 other read ignored", modem_chg, chan_bit(2));
    msr_rd[2] = 1'b1; cyc(1); msr_rd = '0;
    chk("R6 own read clears", modem_chg, 0);
    sleep_en = '1;
    cyc(IDLE + 2);
    chk("R2 sleeps again", asleep, 1);

    for (int i = 0; i < 24; i++)
      wake_and_resleep(int'($urandom % 3), int'($urandom % NCH), int'($urandom % 4));

    finish_run();
  end
endmodule